// File: doc/BRIEF.md
# 16-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 16-bit microcontroller core. Each operation is given by a 4-bit opcode, a byte/word size select, a destination operand, a source operand and the carry bit taken from the status register. The result, the write-back enable and the flag-update mask are combinational. The four status flags (N, Z, C, V) are registered. They change on the rising clock edge of a cycle in which `exec_en` is high, and only for the flags that the opcode's mask selects.

Two-operand operations take `dst_val` as the left operand and `src_val` as the right operand. Subtraction is formed as `dst + ~src + 1`, so C=1 means no borrow. One-operand operations act on `dst_val` and ignore `src_val`. Operand fetch, addressing and the register file sit outside the block.

The block has no state machine. Its only sequential state is the flag register, which has two conditions: it is held, or it is updated under the mask.

Top module: `alu16_status`

## Requirements
- R1: ADD (opcode 0) returns dst+src, and ADDC (opcode 1) returns dst+src+carry_in. C is the unsigned carry out of the selected size. V is set when both operands have the same sign and the result's sign differs from it.
- R2: SUB (opcode 2) returns dst+~src+1, and SUBC (opcode 3) returns dst+~src+carry_in. C is the carry out of the selected size, so C=1 means no borrow. V is the signed overflow of that sum.
- R3: CMP (opcode 4) sets flags exactly as SUB does, and BIT (opcode 7) sets flags exactly as AND does. For both, wb_en stays 0.
- R4: DADD (opcode 5) adds the two operands as packed decimal digits, 2 digits in byte mode and 4 in word mode, plus carry_in. C is set when the decimal sum exceeds 99 (byte) or 9999 (word). DADD updates N, Z and C and leaves V unchanged.
- R5: AND (opcode 6), BIT and XOR (opcode 10) set C to "result non-zero". AND and BIT clear V. XOR sets V when both operands have their sign bit set.
- R6: BIC (opcode 8) returns dst AND NOT src, and BIS (opcode 9) returns dst OR src. Neither changes any flag.
- R7: RRC (opcode 11) shifts dst right one place within the selected size. carry_in enters the top bit of that size, old bit 0 goes to C, and V is cleared.
- R8: RRA (opcode 12) shifts dst right one place within the selected size and keeps the sign bit. Old bit 0 goes to C, and V is cleared.
- R9: SWPB (opcode 13) swaps the two bytes of dst and changes no flag. SXT (opcode 14) copies dst bit 7 into bits 15..8, sets C to "result non-zero" and clears V. Both always work on the full 16-bit word, whatever byte_mode is.
- R10: N is the sign bit of the selected size: bit 7 in byte mode, bit 15 in word mode or for SWPB/SXT. Z is set when the result is zero.
- R11: In byte mode (byte_mode=1) only the low 8 bits of each operand are used, and result bits 15..8 are 0. SWPB and SXT are the exception.
- R12: flag_mask bit 3 stands for V, bit 2 for N, bit 1 for Z and bit 0 for C. A flag takes its new value on the clock edge only when exec_en=1 and its mask bit is 1. Otherwise it keeps its value, including in every cycle where exec_en=0.
- R13: Opcode 15 is a no-operation. It gives result 0, wb_en=0 and flag_mask 0. For every other opcode except CMP and BIT, wb_en equals exec_en.
- R14: While rst_n is low, all four flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | Operation valid this cycle |
| opcode | input | 4 | Operation select |
| byte_mode | input | 1 | 1 = byte size, 0 = word size |
| dst_val | input | 16 | Destination (left) operand |
| src_val | input | 16 | Source (right) operand |
| carry_in | input | 1 | Carry from the status register |
| result | output | 16 | Combinational result |
| wb_en | output | 1 | Result is to be written back |
| flag_mask | output | 4 | Flags this opcode updates ({V,N,Z,C}) |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The assertions assume three things about the inputs. First, exec_en is low during reset. Second, the opcode and operands stay stable from one falling edge to the next, so a flag registered at a rising edge reflects the combinational result visible at that edge. Third, DADD is given only valid decimal digits (each nibble 0 to 9), because the carry rule is defined only for them. The stimulus drives every input at the falling edge, feeds DADD only well-formed packed-decimal operands, and keeps exec_en low until reset has been released.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_CMP  = 4'd4,
        OP_DADD = 4'd5,
        OP_AND  = 4'd6,
        OP_BIT  = 4'd7,
        OP_BIC  = 4'd8,
        OP_BIS  = 4'd9,
        OP_XOR  = 4'd10,
        OP_RRC  = 4'd11,
        OP_RRA  = 4'd12,
        OP_SWPB = 4'd13,
        OP_SXT  = 4'd14,
        OP_NOP  = 4'd15
    } alu_op_e;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int NUM_FLAGS = 4;

    // Which flags each opcode is allowed to change, {V,N,Z,C}
    function automatic logic [NUM_FLAGS-1:0] op_flag_mask(input alu_op_e op);
        logic [NUM_FLAGS-1:0] m;
        unique case (op)
            OP_DADD:                         m = 4'b0111;
            OP_BIC, OP_BIS, OP_SWPB, OP_NOP: m = 4'b0000;
            default:                         m = 4'b1111;
        endcase
        return m;
    endfunction

    function automatic logic op_writes(input alu_op_e op);
        return !(op inside {OP_CMP, OP_BIT, OP_NOP});
    endfunction

endpackage

// File: rtl/alu16_addsub.sv
`timescale 1ns/1ps
module alu16_addsub #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [DATA_W-1:0] wmask,
    input  logic              byte_sel,
    input  logic              is_sub,
    input  logic              use_cin,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              c_out,
    output logic              v_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic              cin_eff;
    logic [DATA_W:0]   full;
    logic              sa, sb, sr;

    assign b_eff   = is_sub ? (~b_in & wmask) : b_in;
    assign cin_eff = use_cin ? carry_in : is_sub;
    assign full    = {1'b0, a_in} + {1'b0, b_eff} + (DATA_W+1)'(cin_eff);
    assign sum_out = full[DATA_W-1:0] & wmask;
    assign c_out   = byte_sel ? full[HALF_W] : full[DATA_W];

    assign sa = byte_sel ? a_in[HALF_W-1]    : a_in[DATA_W-1];
    assign sb = byte_sel ? b_eff[HALF_W-1]   : b_eff[DATA_W-1];
    assign sr = byte_sel ? sum_out[HALF_W-1] : sum_out[DATA_W-1];
    assign v_out = (sa == sb) && (sr != sa);

endmodule

// File: rtl/alu16_bcd.sv
`timescale 1ns/1ps
module alu16_bcd #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [DATA_W-1:0] wmask,
    input  logic              byte_sel,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              c_out
);
    localparam int DIGITS = DATA_W / 4;

    logic [DIGITS:0]   dcy;
    logic [DATA_W-1:0] digits;

    assign dcy[0] = carry_in;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [4:0] dsum;
        logic       over;
        assign dsum = {1'b0, a_in[4*g +: 4]} + {1'b0, b_in[4*g +: 4]} + {4'b0, dcy[g]};
        assign over = dsum > 5'd9;
        assign digits[4*g +: 4] = over ? (dsum[3:0] + 4'd6) : dsum[3:0];
        assign dcy[g+1] = over;
    end

    assign sum_out = digits & wmask;
    assign c_out   = byte_sel ? dcy[DIGITS/2] : dcy[DIGITS];

endmodule

// File: rtl/alu16_logic.sv
`timescale 1ns/1ps
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              byte_sel,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res_out,
    output logic              c_out,
    output logic              v_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] sign_m;
    assign sign_m = byte_sel ? (DATA_W'(1) << (HALF_W-1)) : (DATA_W'(1) << (DATA_W-1));

    always_comb begin
        res_out = '0;
        c_out   = 1'b0;
        v_out   = 1'b0;
        unique case (op)
            OP_AND, OP_BIT: begin
                res_out = a_in & b_in;
                c_out   = |res_out;
            end
            OP_XOR: begin
                res_out = a_in ^ b_in;
                c_out   = |res_out;
                v_out   = (|(a_in & sign_m)) && (|(b_in & sign_m));
            end
            OP_BIC: res_out = a_in & ~b_in;
            OP_BIS: res_out = a_in | b_in;
            OP_RRC: begin
                res_out = (a_in >> 1) | (carry_in ? sign_m : '0);
                c_out   = a_in[0];
            end
            OP_RRA: begin
                res_out = (a_in >> 1) | (a_in & sign_m);
                c_out   = a_in[0];
            end
            OP_SWPB: res_out = {a_in[HALF_W-1:0], a_in[DATA_W-1:HALF_W]};
            OP_SXT: begin
                res_out = {{HALF_W{a_in[HALF_W-1]}}, a_in[HALF_W-1:0]};
                c_out   = |res_out;
            end
            default: res_out = '0;
        endcase
    end

endmodule

// File: rtl/alu16_flag_reg.sv
`timescale 1ns/1ps
module alu16_flag_reg #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic [NF-1:0] mask,
    input  logic [NF-1:0] new_flags,
    output logic [NF-1:0] flags_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (upd_en) begin
            flags_q <= (flags_q & ~mask) | (new_flags & mask);
        end
    end

    for (genvar gi = 0; gi < NF; gi++) begin : g_hold
        // R12
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(upd_en && mask[gi]) |=> $stable(flags_q[gi]));
    end

endmodule

// File: rtl/alu16_status.sv
`timescale 1ns/1ps
module alu16_status
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [3:0]        opcode,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              wb_en,
    output logic [3:0]        flag_mask,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);
    localparam int HALF_W = DATA_W / 2;

    alu_op_e           op;
    logic              full_w;
    logic [DATA_W-1:0] wmask, opa, opb;
    logic [DATA_W-1:0] as_sum, bcd_sum, lg_res, res_sel;
    logic              as_c, as_v, bcd_c, lg_c, lg_v, c_sel, v_sel;
    logic              n_new, z_new;
    logic [NUM_FLAGS-1:0] new_flags, flags_q;

    assign op     = alu_op_e'(opcode);
    assign full_w = !byte_mode || (op inside {OP_SWPB, OP_SXT});
    assign wmask  = full_w ? '1 : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    assign opa    = dst_val & wmask;
    assign opb    = src_val & wmask;

    alu16_addsub #(.DATA_W(DATA_W)) addsub_i (
        .a_in(opa), .b_in(opb), .wmask(wmask), .byte_sel(!full_w),
        .is_sub(op inside {OP_SUB, OP_SUBC, OP_CMP}),
        .use_cin(op inside {OP_ADDC, OP_SUBC}),
        .carry_in(carry_in), .sum_out(as_sum), .c_out(as_c), .v_out(as_v)
    );

    alu16_bcd #(.DATA_W(DATA_W)) bcd_i (
        .a_in(opa), .b_in(opb), .wmask(wmask), .byte_sel(!full_w),
        .carry_in(carry_in), .sum_out(bcd_sum), .c_out(bcd_c)
    );

    alu16_logic #(.DATA_W(DATA_W)) logic_i (
        .op(op), .a_in(opa), .b_in(opb), .byte_sel(!full_w),
        .carry_in(carry_in), .res_out(lg_res), .c_out(lg_c), .v_out(lg_v)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                res_sel = as_sum;
                c_sel   = as_c;
                v_sel   = as_v;
            end
            OP_DADD: begin
                res_sel = bcd_sum;
                c_sel   = bcd_c;
                v_sel   = 1'b0;
            end
            OP_NOP: begin
                res_sel = '0;
                c_sel   = 1'b0;
                v_sel   = 1'b0;
            end
            default: begin
                res_sel = lg_res;
                c_sel   = lg_c;
                v_sel   = lg_v;
            end
        endcase
    end

    assign n_new = full_w ? res_sel[DATA_W-1] : res_sel[HALF_W-1];
    assign z_new = (res_sel == '0);

    always_comb begin
        new_flags        = '0;
        new_flags[FLG_C] = c_sel;
        new_flags[FLG_Z] = z_new;
        new_flags[FLG_N] = n_new;
        new_flags[FLG_V] = v_sel;
    end

    assign result    = res_sel;
    assign flag_mask = op_flag_mask(op);
    assign wb_en     = exec_en && op_writes(op);

    alu16_flag_reg #(.NF(NUM_FLAGS)) flags_i (
        .clk(clk), .rst_n(rst_n), .upd_en(exec_en), .mask(flag_mask),
        .new_flags(new_flags), .flags_q(flags_q)
    );

    assign flag_c = flags_q[FLG_C];
    assign flag_z = flags_q[FLG_Z];
    assign flag_n = flags_q[FLG_N];
    assign flag_v = flags_q[FLG_V];

    // R11
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode && !(op inside {OP_SWPB, OP_SXT})) |-> (result[DATA_W-1:HALF_W] == '0));

    // R3
    cmp_bit_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> !(op inside {OP_CMP, OP_BIT, OP_NOP}));

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && flag_mask[FLG_Z]) |=> (flag_z == ($past(result) == '0)));

    // R6
    flags_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (op inside {OP_BIC, OP_BIS, OP_SWPB}))
        |=> $stable({flag_v, flag_n, flag_z, flag_c}));

endmodule

// File: tb/alu16_status_tb_top.sv
`timescale 1ns/1ps
module alu16_status_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [3:0]  opcode = 4'd15;
    logic        byte_mode = 1'b0;
    logic [15:0] dst_val = '0;
    logic [15:0] src_val = '0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        wb_en;
    logic [3:0]  flag_mask;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int failures = 0;
    logic [3:0] mflags = 4'b0000;  // model {V,N,Z,C}

    typedef struct {
        logic [15:0] res;
        logic        wb;
        logic [3:0]  mask;
        logic [3:0]  flags;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    alu16_status dut_i (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
        .byte_mode(byte_mode), .dst_val(dst_val), .src_val(src_val),
        .carry_in(carry_in), .result(result), .wb_en(wb_en),
        .flag_mask(flag_mask), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model(input int op, input bit byt, input int d, input int s, input bit ci,
                         output int r, output int mask, output bit wb, output bit c, output bit v);
        int w, m, a, b, sbit, full, nb, cc, da, db, sum, lim, nd;
        w = (byt && op != 13 && op != 14) ? 8 : 16;
        m = (1 << w) - 1;
        a = d & m; b = s & m; sbit = 1 << (w - 1);
        r = 0; c = 0; v = 0; mask = 15; wb = 1;
        case (op)
            0, 1: begin
                full = a + b + ((op == 1) ? int'(ci) : 0);
                r = full & m; c = ((full >> w) & 1) != 0;
                v = ((a & sbit) == (b & sbit)) && ((r & sbit) != (a & sbit));
            end
            2, 3, 4: begin
                nb = (~s) & m; cc = (op == 3) ? int'(ci) : 1;
                full = a + nb + cc;
                r = full & m; c = ((full >> w) & 1) != 0;
                v = ((a & sbit) == (nb & sbit)) && ((r & sbit) != (a & sbit));
                wb = (op != 4);
            end
            5: begin
                nd = w / 4; da = 0; db = 0;
                for (int k = nd - 1; k >= 0; k--) begin
                    da = da * 10 + ((a >> (4 * k)) & 15);
                    db = db * 10 + ((b >> (4 * k)) & 15);
                end
                sum = da + db + int'(ci);
                lim = (w == 8) ? 100 : 10000;
                c = sum >= lim; sum = sum % lim;
                for (int k = 0; k < nd; k++) begin
                    r = r | ((sum % 10) << (4 * k));
                    sum = sum / 10;
                end
                mask = 7;
            end
            6, 7: begin r = a & b; c = r != 0; wb = (op == 6); end
            8: begin r = a & ~b & m; mask = 0; end
            9: begin r = a | b; mask = 0; end
            10: begin r = a ^ b; c = r != 0; v = ((a & sbit) != 0) && ((b & sbit) != 0); end
            11: begin r = (a >> 1) | (ci ? sbit : 0); c = (a & 1) != 0; end
            12: begin r = (a >> 1) | (a & sbit); c = (a & 1) != 0; end
            13: begin r = ((d & 255) << 8) | ((d >> 8) & 255); mask = 0; end
            14: begin r = ((d & 128) != 0) ? ((d | 'hFF00) & 'hFFFF) : (d & 255); c = r != 0; end
            default: begin r = 0; mask = 0; wb = 0; end
        endcase
    endtask

    // Driver: compute expectation, push to scoreboard, drive at falling edge
    task automatic do_op(input int op, input bit byt, input int d, input int s, input bit ci,
                         input string tag);
        exp_t e;
        int r, mask, sbit;
        bit wb, c, v, n, z;
        logic [3:0] nf;
        model(op, byt, d, s, ci, r, mask, wb, c, v);
        sbit = (byt && op != 13 && op != 14) ? 'h80 : 'h8000;
        n = (r & sbit) != 0; z = (r == 0);
        nf = {v, n, z, c};
        mflags = (mflags & ~mask[3:0]) | (nf & mask[3:0]);
        e.res = r[15:0]; e.wb = wb; e.mask = mask[3:0]; e.flags = mflags; e.tag = tag;
        @(negedge clk);
        sb_q.push_back(e);
        opcode = op[3:0]; byte_mode = byt; dst_val = d[15:0]; src_val = s[15:0];
        carry_in = ci; exec_en = 1'b1;
    endtask

    // Monitor: after each active edge with an operation, compare
    always @(posedge clk) begin
        #1;
        if (rst_n && exec_en) begin
            if (sb_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL scoreboard empty actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, "result", int'(result), int'(e.res));
                chk(e.tag, "wb_en", int'(wb_en), int'(e.wb));
                chk(e.tag, "flag_mask", int'(flag_mask), int'(e.mask));
                chk(e.tag, "flags", int'({flag_v, flag_n, flag_z, flag_c}), int'(e.flags));
            end
        end
    end

    initial begin
        #(200000 * 5);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R14: flags cleared under reset
        chk("R14", "reset flags", int'({flag_v, flag_n, flag_z, flag_c}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_op(0, 0, 'h7FFF, 'h0001, 0, "R1 add signed overflow");
        do_op(0, 0, 'hFFFF, 'h0001, 0, "R1 add carry zero R10");
        do_op(1, 1, 'h0080, 'h0080, 1, "R1 addc byte");
        do_op(0, 1, 'h12F0, 'h3415, 0, "R11 add byte upper ignored");
        do_op(2, 0, 'h0005, 'h0003, 0, "R2 sub no borrow");
        do_op(2, 0, 'h0003, 'h0005, 0, "R2 sub borrow negative");
        do_op(3, 0, 'h0005, 'h0003, 0, "R2 subc cin0");
        do_op(2, 1, 'h0080, 'h0001, 0, "R2 sub byte overflow");
        do_op(4, 0, 'h1234, 'h1234, 0, "R3 cmp equal");
        do_op(7, 0, 'h00F0, 'h0F00, 0, "R3 bit zero");
        do_op(5, 1, 'h0045, 'h0055, 0, "R4 dadd byte 100");
        do_op(5, 0, 'h9999, 'h0001, 0, "R4 dadd word wrap");
        do_op(5, 0, 'h1234, 'h4321, 1, "R4 dadd with carry");
        do_op(6, 0, 'hF0F0, 'h0FF0, 0, "R5 and nonzero");
        do_op(10, 0, 'h8000, 'h8001, 0, "R5 xor both negative");
        do_op(6, 0, 'h00FF, 'hFF00, 0, "R5 and zero");
        do_op(8, 0, 'hFFFF, 'h00F0, 0, "R6 bic");
        do_op(9, 0, 'h1200, 'h0034, 0, "R6 bis");
        do_op(11, 0, 'h0001, 'h0000, 1, "R7 rrc word");
        do_op(11, 1, 'h5502, 'h0000, 1, "R7 rrc byte");
        do_op(12, 0, 'h8002, 'h0000, 0, "R8 rra word");
        do_op(12, 1, 'h0081, 'h0000, 0, "R8 rra byte");
        do_op(13, 1, 'h12AB, 'h0000, 0, "R9 swpb");
        do_op(14, 1, 'h0080, 'h0000, 0, "R9 sxt");
        do_op(15, 0, 'hFFFF, 'hFFFF, 1, "R13 nop");
        @(negedge clk);
        exec_en = 1'b0;

        // R12: an operation presented with exec_en low leaves flags unchanged
        opcode = 4'd0; byte_mode = 1'b0; dst_val = 16'hFFFF; src_val = 16'h0001;
        @(posedge clk); #1;
        chk("R12", "flags held", int'({flag_v, flag_n, flag_z, flag_c}), int'(mflags));
        chk("R13", "wb_en idle", int'(wb_en), 0);

        repeat (3) @(negedge clk);
        chk("R12", "scoreboard drained", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule